// File: doc/BRIEF.md
# Trace Window and Trigger Controller

This block decides when instruction trace may flow. Four watchpoint-match pulses are combined through two programmable selection masks: a hit on any input selected by the start mask opens a trace window, and a hit on any input selected by the stop mask closes it. The window state is kept as a status bit. Software can also load that bit directly. A window-enable bit chooses whether the trace-enable output follows the window or ignores it. A programming bit, set out of reset, suppresses trace while the unit is being configured. A read-only copy of that bit lets software poll for it.

The block also latches a one-shot trigger. The first trigger event seen while the unit is out of programming produces a single-cycle trigger pulse and sets a sticky trigger status bit. Later events are then refused until software takes the programming bit from 1 back to 0. If debug requests are enabled, the same trigger raises a debug request to the core. That request stays high until the core acknowledges it.

Configuration arrives through a small register-write port with a 2-bit register select. Select 0 is the control register, select 1 is the window configuration, select 2 is the window status, and select 3 is a spare slot.

Top module: `trace_window_unit`

## Requirements
- R1: After reset the programming bit reads 1, and the window status, trigger status, trigger pulse, debug request and trace enable all read 0.
- R2: The start mask sits in window-configuration bits [3:0], with bit k selecting watchpoint input k (bit 0 is the first input). A hit on a selected input sets the window status from the next clock edge. Hits on unselected inputs leave the status unchanged.
- R3: The stop mask sits in window-configuration bits [19:16], with bit 16+k selecting input k. A hit on a selected input clears the window status from the next clock edge.
- R4: When a start hit and a stop hit fall in the same cycle, the window status ends at 0.
- R5: Window-configuration bit 25 is the window enable. When it is 1, trace enable equals the window status while programming is 0. When it is 0, trace enable is 1 whenever programming is 0.
- R6: Control bit 0 is the programming bit. While it is 1, trace enable is 0. The programming-status output always equals its current value.
- R7: A trigger event seen while programming is 0 and the trigger status is 0 gives a trigger pulse of exactly one cycle, after the next edge, and sets the trigger status. Events seen while the trigger status is 1, or while programming is 1, give no pulse.
- R8: A control write that takes the programming bit from 1 to 0 clears the trigger status and re-arms the trigger. Setting the programming bit does not clear the trigger status.
- R9: With control bit 1 (debug-request enable) set when the trigger fires, the debug request rises together with the trigger pulse. It holds until debug acknowledge is sampled high, then drops at the next edge. With the enable clear, no debug request is raised.
- R10: A write to window status (select 2) loads bit 0 into the window status. Such a write takes priority over watchpoint hits in the same cycle.
- R11: Writes to select 3 change no state and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wpHit | input | NUM_WP | Watchpoint-match pulses, one per input |
| trigEvent | input | 1 | Trigger event pulse |
| dbgAck | input | 1 | Debug acknowledge from the core |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 window config, 2 window status, 3 spare |
| wrData | input | DATA_W | Register write data |
| traceEn | output | 1 | Trace enable |
| trigOut | output | 1 | One-cycle trigger pulse |
| dbgReq | output | 1 | Debug request, held until acknowledged |
| statWindow | output | 1 | Window status |
| statTrigger | output | 1 | Sticky trigger status |
| statProg | output | 1 | Effective programming bit |

## Verification
A start hit and a stop hit can land in the same cycle, and a window-status write can coincide with either of them. The bench loads every pair of start and stop masks, presets the window status to both values, and drives every pattern on the four watchpoint inputs. It judges each resulting status against an arithmetic rule: stop beats start, and a hit with no selected input holds the preset value. It then applies a status write together with a start hit and expects the written value to win.

// File: rtl/trace_gate_pkg.sv
package trace_gate_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_WIN   = 2'd1,
    SEL_STAT  = 2'd2,
    SEL_SPARE = 2'd3
  } reg_sel_e;

  // strobes from control to datapath, one cycle each
  typedef struct packed {
    logic ldCtrl;
    logic ldWin;
    logic ldStat;
    logic winSet;
    logic winClr;
    logic trigFire;
    logic rearm;
    logic ackSeen;
  } strobe_t;

endpackage

// File: rtl/trace_gate_ctrl.sv
module trace_gate_ctrl
  import trace_gate_pkg::*;
#(
  parameter int NUM_WP = 4
) (
  input  logic [NUM_WP-1:0] wpHit,
  input  logic              trigEvent,
  input  logic              dbgAck,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic              wrBit0,
  input  logic [NUM_WP-1:0] startMask,
  input  logic [NUM_WP-1:0] stopMask,
  input  logic              progBit,
  input  logic              trigLatched,
  output strobe_t           strb
);

  logic [NUM_WP-1:0] startSel;
  logic [NUM_WP-1:0] stopSel;

  for (genvar i = 0; i < NUM_WP; i++) begin : g_sel
    assign startSel[i] = wpHit[i] & startMask[i];
    assign stopSel[i]  = wpHit[i] & stopMask[i];
  end

  reg_sel_e sel;
  assign sel = reg_sel_e'(wrAddr);

  always_comb begin
    strb          = '0;
    strb.ldCtrl   = wrEn && (sel == SEL_CTRL);
    strb.ldWin    = wrEn && (sel == SEL_WIN);
    strb.ldStat   = wrEn && (sel == SEL_STAT);
    // stop has priority over start
    strb.winClr   = |stopSel;
    strb.winSet   = (|startSel) && !(|stopSel);
    strb.trigFire = trigEvent && !progBit && !trigLatched;
    strb.rearm    = strb.ldCtrl && progBit && !wrBit0;
    strb.ackSeen  = dbgAck;
  end

endmodule

// File: rtl/trace_gate_dp.sv
module trace_gate_dp
  import trace_gate_pkg::*;
#(
  parameter int NUM_WP     = 4,
  parameter int DATA_W     = 32,
  parameter int START_LSB  = 0,
  parameter int STOP_LSB   = 16,
  parameter int WIN_EN_BIT = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wrData,
  output logic              progBit,
  output logic              dbgEn,
  output logic              winEn,
  output logic [NUM_WP-1:0] startMask,
  output logic [NUM_WP-1:0] stopMask,
  output logic              winState,
  output logic              trigLatched,
  output logic              trigPulse,
  output logic              dbgReqQ,
  output logic              traceEn
);

  localparam int StartMsb = START_LSB + NUM_WP - 1;
  localparam int StopMsb  = STOP_LSB + NUM_WP - 1;

  logic unusedWrBits;
  assign unusedWrBits = ^wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      progBit <= 1'b1;
      dbgEn   <= 1'b0;
    end else if (strb.ldCtrl) begin
      progBit <= wrData[0];
      dbgEn   <= wrData[1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startMask <= '0;
      stopMask  <= '0;
      winEn     <= 1'b0;
    end else if (strb.ldWin) begin
      startMask <= wrData[StartMsb:START_LSB];
      stopMask  <= wrData[StopMsb:STOP_LSB];
      winEn     <= wrData[WIN_EN_BIT];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              winState <= 1'b0;
    else if (strb.ldStat)   winState <= wrData[0];
    else if (strb.winClr)   winState <= 1'b0;
    else if (strb.winSet)   winState <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigLatched <= 1'b0;
      trigPulse   <= 1'b0;
      dbgReqQ     <= 1'b0;
    end else begin
      trigPulse <= strb.trigFire;
      if (strb.trigFire)   trigLatched <= 1'b1;
      else if (strb.rearm) trigLatched <= 1'b0;
      if (strb.trigFire && dbgEn) dbgReqQ <= 1'b1;
      else if (strb.ackSeen)      dbgReqQ <= 1'b0;
    end
  end

  assign traceEn = !progBit && (!winEn || winState);

endmodule

// File: rtl/trace_window_unit.sv
module trace_window_unit
  import trace_gate_pkg::*;
#(
  parameter int NUM_WP     = 4,
  parameter int DATA_W     = 32,
  parameter int START_LSB  = 0,
  parameter int STOP_LSB   = 16,
  parameter int WIN_EN_BIT = 25
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_WP-1:0] wpHit,
  input  logic              trigEvent,
  input  logic              dbgAck,
  input  logic              wrEn,
  input  logic [1:0]        wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              traceEn,
  output logic              trigOut,
  output logic              dbgReq,
  output logic              statWindow,
  output logic              statTrigger,
  output logic              statProg
);

  strobe_t           strb;
  logic              progBit;
  logic              dbgEn;
  logic              winEn;
  logic [NUM_WP-1:0] startMask;
  logic [NUM_WP-1:0] stopMask;
  logic              winState;
  logic              trigLatched;

  trace_gate_ctrl #(.NUM_WP(NUM_WP)) u_ctrl (
    .wpHit       (wpHit),
    .trigEvent   (trigEvent),
    .dbgAck      (dbgAck),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .wrBit0      (wrData[0]),
    .startMask   (startMask),
    .stopMask    (stopMask),
    .progBit     (progBit),
    .trigLatched (trigLatched),
    .strb        (strb)
  );

  trace_gate_dp #(
    .NUM_WP(NUM_WP), .DATA_W(DATA_W), .START_LSB(START_LSB),
    .STOP_LSB(STOP_LSB), .WIN_EN_BIT(WIN_EN_BIT)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrData      (wrData),
    .progBit     (progBit),
    .dbgEn       (dbgEn),
    .winEn       (winEn),
    .startMask   (startMask),
    .stopMask    (stopMask),
    .winState    (winState),
    .trigLatched (trigLatched),
    .trigPulse   (trigOut),
    .dbgReqQ     (dbgReq),
    .traceEn     (traceEn)
  );

  assign statWindow  = winState;
  assign statTrigger = trigLatched;
  assign statProg    = progBit;

endmodule

// File: rtl/trace_window_unit_chk.sv
module trace_window_unit_chk #(
  parameter int NUM_WP = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_WP-1:0] wpHit,
  input logic              trigEvent,
  input logic              dbgAck,
  input logic              wrEn,
  input logic [1:0]        wrAddr,
  input logic [NUM_WP-1:0] startMask,
  input logic [NUM_WP-1:0] stopMask,
  input logic              winEn,
  input logic              traceEn,
  input logic              trigOut,
  input logic              dbgReq,
  input logic              statWindow,
  input logic              statTrigger,
  input logic              statProg
);

  logic statWr, ctrlWr;
  assign statWr = wrEn && (wrAddr == 2'd2);
  assign ctrlWr = wrEn && (wrAddr == 2'd0);

  // R6: programming suppresses trace
  assert_prog_blocks_R6: assert property (@(posedge clk) disable iff (!rstN)
    statProg |-> !traceEn);

  // R4: stop hit wins over start hit
  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((|(wpHit & stopMask)) && !statWr) |=> !statWindow);

  // R2: selected start hit without stop opens the window
  assert_start_opens_R2: assert property (@(posedge clk) disable iff (!rstN)
    ((|(wpHit & startMask)) && !(|(wpHit & stopMask)) && !statWr) |=> statWindow);

  // R7: latched trigger refuses further pulses
  assert_trig_once_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statTrigger && !ctrlWr) |=> !trigOut);

  // R7: pulse lasts one cycle and sets status
  assert_trig_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> statTrigger);

  // R9: debug request held until acknowledged
  assert_dbg_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (dbgReq && !dbgAck) |=> dbgReq);

  // R5: window disabled leaves trace on outside programming
  assert_win_off_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!statProg && !winEn) |-> traceEn);

  // R7: no pulse while programming
  assert_prog_no_trig_R7: assert property (@(posedge clk) disable iff (!rstN)
    (statProg && trigEvent && !statTrigger) |=> !trigOut);

endmodule

bind trace_window_unit trace_window_unit_chk #(.NUM_WP(NUM_WP)) u_chk (
  .clk(clk), .rstN(rstN), .wpHit(wpHit), .trigEvent(trigEvent),
  .dbgAck(dbgAck), .wrEn(wrEn), .wrAddr(wrAddr), .startMask(startMask),
  .stopMask(stopMask), .winEn(winEn), .traceEn(traceEn), .trigOut(trigOut),
  .dbgReq(dbgReq), .statWindow(statWindow), .statTrigger(statTrigger),
  .statProg(statProg)
);

// File: tb/trace_window_unit_test.sv
module trace_window_unit_test;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  wpHit = '0;
  logic        trigEvent = 1'b0;
  logic        dbgAck = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic traceEn, trigOut, dbgReq, statWindow, statTrigger, statProg;

  int checks = 0;
  int failures = 0;

  always #(CLK_P/2) clk = ~clk;

  trace_window_unit uut (
    .clk(clk), .rstN(rstN), .wpHit(wpHit), .trigEvent(trigEvent),
    .dbgAck(dbgAck), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .traceEn(traceEn), .trigOut(trigOut), .dbgReq(dbgReq),
    .statWindow(statWindow), .statTrigger(statTrigger), .statProg(statProg)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic hit(input logic [3:0] p);
    wpHit = p;
    @(negedge clk);
    wpHit = '0;
  endtask

  task automatic pulseTrig();
    trigEvent = 1'b1;
    @(negedge clk);
    trigEvent = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic expW;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "statProg", statProg, 1);
    check("R1", "statWindow", statWindow, 0);
    check("R1", "statTrigger", statTrigger, 0);
    check("R1", "trigOut", trigOut, 0);
    check("R1", "dbgReq", dbgReq, 0);
    check("R1", "traceEn", traceEn, 0);

    // R6 trace blocked while programming even with window disabled
    check("R6", "traceEn prog", traceEn, 0);
    regWrite(2'd0, 32'h0);
    check("R6", "statProg cleared", statProg, 0);
    check("R5", "traceEn winEn=0", traceEn, 1);

    // sweep masks, hit patterns and preset window value
    for (int sm = 0; sm < 16; sm++) begin
      for (int pm = 0; pm < 16; pm++) begin
        regWrite(2'd1, (32'(pm) << 16) | 32'(sm) | (32'h1 << 25));
        for (int pat = 0; pat < 16; pat++) begin
          for (int w0 = 0; w0 < 2; w0++) begin
            regWrite(2'd2, 32'(w0));
            hit(4'(pat));
            if ((pat & pm) != 0) expW = 1'b0;
            else if ((pat & sm) != 0) expW = 1'b1;
            else expW = 1'(w0);
            if (((pat & pm) != 0) && ((pat & sm) != 0))
              check("R4", "window start+stop", statWindow, expW);
            else if ((pat & pm) != 0)
              check("R3", "window stop", statWindow, expW);
            else if ((pat & sm) != 0)
              check("R2", "window start", statWindow, expW);
            else
              check("R2", "window unselected", statWindow, expW);
            check("R5", "traceEn follows window", traceEn, expW);
          end
        end
      end
    end

    // R10 status write beats a start hit in the same cycle
    regWrite(2'd1, 32'h0000_000F);
    regWrite(2'd2, 32'h0);
    wpHit = 4'hF; wrEn = 1'b1; wrAddr = 2'd2; wrData = 32'h0;
    @(negedge clk);
    wpHit = '0; wrEn = 1'b0;
    check("R10", "status write priority", statWindow, 0);
    regWrite(2'd2, 32'h1);
    check("R10", "status write load", statWindow, 1);

    // R11 spare select ignored
    regWrite(2'd3, 32'hFFFF_FFFF);
    check("R11", "statWindow", statWindow, 1);
    check("R11", "statProg", statProg, 0);
    check("R11", "traceEn", traceEn, 1);
    regWrite(2'd2, 32'h0);
    check("R11", "winEn kept (traceEn)", traceEn, 1);

    // R6 programming again suppresses
    regWrite(2'd0, 32'h1);
    check("R6", "traceEn prog set", traceEn, 0);
    check("R6", "statProg set", statProg, 1);
    pulseTrig();
    check("R7", "no trigger while programming", trigOut, 0);
    check("R7", "no status while programming", statTrigger, 0);

    // R7/R9 trigger with debug request
    regWrite(2'd0, 32'h2);
    pulseTrig();
    check("R7", "trigOut pulse", trigOut, 1);
    check("R7", "statTrigger set", statTrigger, 1);
    check("R9", "dbgReq raised", dbgReq, 1);
    @(negedge clk);
    check("R7", "pulse one cycle", trigOut, 0);
    check("R9", "dbgReq held", dbgReq, 1);
    pulseTrig();
    check("R7", "second event refused", trigOut, 0);
    check("R9", "dbgReq still held", dbgReq, 1);
    dbgAck = 1'b1;
    @(negedge clk);
    dbgAck = 1'b0;
    check("R9", "dbgReq dropped on ack", dbgReq, 0);

    // R8 setting prog keeps status, clearing re-arms
    regWrite(2'd0, 32'h1);
    check("R8", "status kept on set", statTrigger, 1);
    regWrite(2'd0, 32'h0);
    check("R8", "status cleared on 1->0", statTrigger, 0);
    pulseTrig();
    check("R8", "re-armed trigger fires", trigOut, 1);
    check("R9", "no dbgReq when disabled", dbgReq, 0);
    regWrite(2'd0, 32'h0);
    check("R8", "0->0 write keeps status", statTrigger, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule